// File: doc/BRIEF.md
# Processor Bus Address and Strobe Decoder

This combinational unit sits between an 8-bit processor with a 16-bit address bus and the memory and peripheral devices around it. From the processor's memory-or-I/O status line and its active-low read and write strobes it derives four separate active-low strobes. There is a memory read, a memory write, an I/O read and an I/O write. From the address bus it produces eight active-low chip selects, one for each 8 KiB memory device. Each device sees address bits 12..0 directly. The unit also produces active-low select lines for a small set of input and output ports.

Two build-time choices shape the address map. The first places the ports in a separate 8-bit I/O space, reached by the I/O strobes, or in the 16-bit memory space, reached by the memory strobes. In the memory-mapped case a port address takes precedence over the memory device that would otherwise answer there. The second choice selects full or partial decoding. Partial decoding ignores some upper memory-select bits and some port-address bits. Each device then answers at several alias addresses.

Top module: `bus_addr_decoder`

## Requirements
- R1: `mem_rd_n` is low exactly when `io_m`=0, `rd_n`=0 and `wr_n`=1. `mem_wr_n` is low exactly when `io_m`=0, `wr_n`=0 and `rd_n`=1. The two are never low together.
- R2: While `io_m`=1, `mem_rd_n` and `mem_wr_n` both stay high for every value of `rd_n` and `wr_n`.
- R3: `io_rd_n` is low exactly when `io_m`=1, `rd_n`=0 and `wr_n`=1. `io_wr_n` is low exactly when `io_m`=1, `wr_n`=0 and `rd_n`=1. Both stay high while `io_m`=0.
- R4: When `rd_n` and `wr_n` are both high, or both low, every strobe, chip select and port select is high.
- R5: With full decoding, during a memory read or write, `cs_n[n]` is low exactly when `addr[15:13]` equals n. Chip n therefore covers n*0x2000 to n*0x2000+0x1FFF. Outside memory cycles all chip selects are high.
- R6: With partial decoding, only the lowest `MEM_PART_BITS` of `addr[15:13]` choose the chip, and the higher bits are ignored. Only chips 0 to 2^`MEM_PART_BITS`-1 are ever selected, and every alias range reaches the same chip.
- R7: At most one line among `cs_n`, `port_in_n` and `port_out_n` is low at any time.
- R8: In isolated-I/O mode, `port_in_n[k]` goes low during an I/O read, and `port_out_n[k]` during an I/O write, when `addr[7:0]` matches `PORT_BASE`+k on every bit not set in the ignore mask. `addr[15:8]` is ignored. The ignore mask is `IO_IGNORE_MASK` with partial decoding and zero with full decoding.
- R9: In memory-mapped mode, `port_in_n[k]` goes low during a memory read, and `port_out_n[k]` during a memory write, when `addr` matches `MMIO_BASE`+k on all 16 bits except the ignore-mask bits in the low byte. At such an address every chip select stays high.
- R10: In isolated mode, memory cycles never drive a port select low. In memory-mapped mode, I/O cycles never drive a port select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_m | input | 1 | Status line: 1 marks an I/O cycle, 0 a memory cycle |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| addr | input | 16 | Processor address bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| cs_n | output | 8 | Chip selects for the eight 8 KiB devices, active low |
| port_in_n | output | NUM_PORTS | Input-port selects, active low |
| port_out_n | output | NUM_PORTS | Output-port selects, active low |

## Verification
The unit holds no state, so a fault in a decode term appears at the ports on the same bus cycle that exercises it. It shows as a strobe asserted for the wrong cycle type, a wrong or duplicated chip select, or a port select that misses an alias or collides with memory. The bench sweeps addresses across the whole 64 KiB space for every status and strobe combination, and adds every chip boundary, port address and port alias. A mis-wired select bit or ignore mask therefore shows up within one sweep step of the region it affects. Two builds run side by side: isolated I/O with full decoding, and memory-mapped I/O with partial decoding.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

    localparam int ADDR_W    = 16;
    localparam int DEV_AW    = 13;
    localparam int SEL_W     = ADDR_W - DEV_AW;
    localparam int NUM_CHIPS = 1 << SEL_W;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } bus_dir_e;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobe_t;

    // Both strobes low is not a legal cycle and is treated as idle.
    function automatic bus_dir_e classify(input logic rd_n, input logic wr_n);
        if (!rd_n && wr_n)      return CYC_READ;
        else if (rd_n && !wr_n) return CYC_WRITE;
        else                    return CYC_IDLE;
    endfunction

    function automatic logic [SEL_W-1:0] sel_keep_mask(input int bits);
        logic [SEL_W-1:0] m;
        for (int i = 0; i < SEL_W; i++) m[i] = (i < bits);
        return m;
    endfunction

endpackage

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_dec_pkg::*;
(
    input  logic    io_m,
    input  logic    rd_n,
    input  logic    wr_n,
    output strobe_t stb
);

    bus_dir_e dir;

    always_comb begin
        dir          = classify(rd_n, wr_n);
        stb.mem_rd_n = !((dir == CYC_READ)  && !io_m);
        stb.mem_wr_n = !((dir == CYC_WRITE) && !io_m);
        stb.io_rd_n  = !((dir == CYC_READ)  &&  io_m);
        stb.io_wr_n  = !((dir == CYC_WRITE) &&  io_m);
    end

    always_comb begin
        // R1
        mem_excl_chk: assert (stb.mem_rd_n || stb.mem_wr_n)
            else $error("memory read and write strobes low together");
        // R2
        mem_quiet_io_chk: assert (!io_m || (stb.mem_rd_n && stb.mem_wr_n))
            else $error("memory strobe active during I/O cycle");
        // R3
        io_quiet_mem_chk: assert (io_m || (stb.io_rd_n && stb.io_wr_n))
            else $error("I/O strobe active during memory cycle");
        // R4
        idle_quiet_chk: assert ((rd_n != wr_n) || (&{stb.mem_rd_n, stb.mem_wr_n, stb.io_rd_n, stb.io_wr_n}))
            else $error("strobe active without a single valid request");
    end

endmodule

// File: rtl/bus_dec3to8.sv
module bus_dec3to8 #(
    parameter int SEL_W = 3
) (
    input  logic                  en_hi,
    input  logic                  en_lo_a_n,
    input  logic                  en_lo_b_n,
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] y_n
);

    localparam int N_OUT = 1 << SEL_W;

    logic enabled;
    assign enabled = en_hi && !en_lo_a_n && !en_lo_b_n;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign y_n[i] = !(enabled && (sel == SEL_W'(i)));
    end

    always_comb begin
        // R7
        dec_onehot_chk: assert ($onehot0(~y_n))
            else $error("decoder drives more than one output low");
        // R5
        dec_disable_chk: assert (enabled || (&y_n))
            else $error("decoder output low while disabled");
    end

endmodule

// File: rtl/bus_chip_select.sv
module bus_chip_select
    import bus_dec_pkg::*;
#(
    parameter int SEL_BITS = SEL_W
) (
    input  logic                 io_m,
    input  strobe_t              stb,
    input  logic                 port_claim,
    input  logic [SEL_W-1:0]     addr_hi,
    output logic [NUM_CHIPS-1:0] cs_n
);

    localparam logic [SEL_W-1:0] KEEP = sel_keep_mask(SEL_BITS);

    logic [SEL_W-1:0] sel;
    logic             mem_any_n;

    // Ignored upper bits are forced to zero, so aliases land on the same chip.
    assign sel       = addr_hi & KEEP;
    assign mem_any_n = stb.mem_rd_n && stb.mem_wr_n;

    bus_dec3to8 #(.SEL_W(SEL_W)) u_dec (
        .en_hi     (!io_m),
        .en_lo_a_n (mem_any_n),
        .en_lo_b_n (port_claim),
        .sel       (sel),
        .y_n       (cs_n)
    );

    always_comb begin
        // R6
        partial_range_chk: assert (SEL_BITS >= SEL_W || (&cs_n[NUM_CHIPS-1:(1<<SEL_BITS)]))
            else $error("chip beyond partial range selected");
        // R4
        cs_idle_chk: assert (!mem_any_n || (&cs_n))
            else $error("chip select without memory strobe");
    end

    logic unused_io;
    assign unused_io = stb.io_rd_n ^ stb.io_wr_n;

endmodule

// File: rtl/bus_port_select.sv
module bus_port_select
    import bus_dec_pkg::*;
#(
    parameter int              NUM_PORTS = 4,
    parameter bit              MMIO      = 1'b0,
    parameter logic [7:0]      PORT_BASE = 8'h40,
    parameter logic [15:0]     MMIO_BASE = 16'hFF40,
    parameter logic [7:0]      IGN_MASK  = 8'h00
) (
    input  strobe_t               stb,
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_PORTS-1:0]  port_in_n,
    output logic [NUM_PORTS-1:0]  port_out_n,
    output logic                  port_claim
);

    localparam logic [ADDR_W-1:0] CMP_MASK = MMIO ? {8'hFF, ~IGN_MASK} : {8'h00, ~IGN_MASK};

    logic                 rd_en_n;
    logic                 wr_en_n;
    logic [NUM_PORTS-1:0] match;

    assign rd_en_n = MMIO ? stb.mem_rd_n : stb.io_rd_n;
    assign wr_en_n = MMIO ? stb.mem_wr_n : stb.io_wr_n;

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        localparam logic [ADDR_W-1:0] P_ADDR =
            MMIO ? (MMIO_BASE + 16'(k)) : {8'h00, (PORT_BASE + 8'(k))};
        assign match[k]      = ((addr ^ P_ADDR) & CMP_MASK) == '0;
        assign port_in_n[k]  = !(match[k] && !rd_en_n);
        assign port_out_n[k] = !(match[k] && !wr_en_n);
    end

    // Only a memory-mapped port takes an address away from the memory space.
    assign port_claim = MMIO && (|match);

    always_comb begin
        // R7
        port_excl_chk: assert ($countones(~{port_in_n, port_out_n}) <= 1)
            else $error("more than one port select low");
        // R10
        port_space_chk: assert ((MMIO ? (stb.mem_rd_n && stb.mem_wr_n) : (stb.io_rd_n && stb.io_wr_n))
                                -> (&{port_in_n, port_out_n}))
            else $error("port select driven by the wrong address space");
    end

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bus_dec_pkg::*;
#(
    parameter bit          MMIO           = 1'b0,
    parameter bit          PARTIAL        = 1'b0,
    parameter int          MEM_PART_BITS  = 2,
    parameter int          NUM_PORTS      = 4,
    parameter logic [7:0]  PORT_BASE      = 8'h40,
    parameter logic [15:0] MMIO_BASE      = 16'hFF40,
    parameter logic [7:0]  IO_IGNORE_MASK = 8'h30
) (
    input  logic                 io_m,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [15:0]          addr,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 io_rd_n,
    output logic                 io_wr_n,
    output logic [7:0]           cs_n,
    output logic [NUM_PORTS-1:0] port_in_n,
    output logic [NUM_PORTS-1:0] port_out_n
);

    localparam int         SEL_BITS = PARTIAL ? MEM_PART_BITS : SEL_W;
    localparam logic [7:0] IGN_EFF  = PARTIAL ? IO_IGNORE_MASK : 8'h00;

    strobe_t stb;
    logic    port_claim;

    bus_strobe_gen u_stb (
        .io_m (io_m),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .stb  (stb)
    );

    bus_port_select #(
        .NUM_PORTS (NUM_PORTS),
        .MMIO      (MMIO),
        .PORT_BASE (PORT_BASE),
        .MMIO_BASE (MMIO_BASE),
        .IGN_MASK  (IGN_EFF)
    ) u_ports (
        .stb        (stb),
        .addr       (addr),
        .port_in_n  (port_in_n),
        .port_out_n (port_out_n),
        .port_claim (port_claim)
    );

    bus_chip_select #(.SEL_BITS(SEL_BITS)) u_cs (
        .io_m       (io_m),
        .stb        (stb),
        .port_claim (port_claim),
        .addr_hi    (addr[ADDR_W-1:DEV_AW]),
        .cs_n       (cs_n)
    );

    assign mem_rd_n = stb.mem_rd_n;
    assign mem_wr_n = stb.mem_wr_n;
    assign io_rd_n  = stb.io_rd_n;
    assign io_wr_n  = stb.io_wr_n;

    always_comb begin
        // R7
        one_select_chk: assert ($countones(~{cs_n, port_in_n, port_out_n}) <= 1)
            else $error("more than one select low");
        // R9
        mmio_claim_chk: assert ((&{port_in_n, port_out_n}) || (&cs_n))
            else $error("port and memory chip selected together");
    end

endmodule

// File: tb/bus_addr_decoder_tb.sv
module bus_addr_decoder_tb;

    localparam int NP = 4;
    localparam logic [7:0]  P_BASE = 8'h40;
    localparam logic [15:0] M_BASE = 16'hFF40;
    localparam logic [7:0]  IGN    = 8'h30;
    localparam int          PBITS  = 2;
    localparam int          WDOG   = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        io_m = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] addr = 16'h0000;

    logic a_mr, a_mw, a_ir, a_iw, b_mr, b_mw, b_ir, b_iw;
    logic [7:0]    a_cs, b_cs;
    logic [NP-1:0] a_pi, a_po, b_pi, b_po;

    // isolated I/O, full decoding
    bus_addr_decoder #(.MMIO(1'b0), .PARTIAL(1'b0), .MEM_PART_BITS(PBITS), .NUM_PORTS(NP),
                       .PORT_BASE(P_BASE), .MMIO_BASE(M_BASE), .IO_IGNORE_MASK(IGN)) u_dut (
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .mem_rd_n(a_mr), .mem_wr_n(a_mw), .io_rd_n(a_ir), .io_wr_n(a_iw),
        .cs_n(a_cs), .port_in_n(a_pi), .port_out_n(a_po));

    // memory-mapped I/O, partial decoding
    bus_addr_decoder #(.MMIO(1'b1), .PARTIAL(1'b1), .MEM_PART_BITS(PBITS), .NUM_PORTS(NP),
                       .PORT_BASE(P_BASE), .MMIO_BASE(M_BASE), .IO_IGNORE_MASK(IGN)) u_dut_mm (
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .mem_rd_n(b_mr), .mem_wr_n(b_mw), .io_rd_n(b_ir), .io_wr_n(b_iw),
        .cs_n(b_cs), .port_in_n(b_pi), .port_out_n(b_po));

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Behavioural address map: {strobes[3:0], cs[7:0], in[3:0], out[3:0]}
    function automatic logic [19:0] model(input bit mmio, input bit part, input logic [15:0] a,
                                          input logic m_io, input logic r_n, input logic w_n);
        logic [3:0]    s;
        logic [7:0]    cs;
        logic [NP-1:0] pin, pout;
        bit rd, wr, mem_c, io_c;
        int hit, chip, bits;
        logic [7:0]  ign;
        logic [15:0] cmp, pa;
        rd    = (r_n == 1'b0) && (w_n == 1'b1);
        wr    = (w_n == 1'b0) && (r_n == 1'b1);
        mem_c = (m_io == 1'b0);
        io_c  = (m_io == 1'b1);
        s     = {!(mem_c && rd), !(mem_c && wr), !(io_c && rd), !(io_c && wr)};
        ign   = part ? IGN : 8'h00;
        bits  = part ? PBITS : 3;
        hit   = -1;
        for (int k = 0; k < NP; k++) begin
            if (mmio) begin
                pa  = M_BASE + 16'(k);
                cmp = {8'hFF, ~ign};
            end else begin
                pa  = {8'h00, P_BASE + 8'(k)};
                cmp = {8'h00, ~ign};
            end
            if (((a ^ pa) & cmp) == 16'h0) hit = k;
        end
        pin  = '1;
        pout = '1;
        if (hit >= 0) begin
            if (mmio ? (mem_c && rd) : (io_c && rd)) pin[hit]  = 1'b0;
            if (mmio ? (mem_c && wr) : (io_c && wr)) pout[hit] = 1'b0;
        end
        cs = '1;
        if (mem_c && (rd || wr) && !(mmio && hit >= 0)) begin
            chip = (int'(a) / 8192) % (1 << bits);
            cs[chip] = 1'b0;
        end
        return {s, cs, pin, pout};
    endfunction

    task automatic cmp_field(input string tag, input string what, input logic [15:0] got,
                             input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%h io_m=%b rd_n=%b wr_n=%b actual=%h expected=%h",
                     tag, what, addr, io_m, rd_n, wr_n, got, exp);
        end
    endtask

    task automatic check_dut(input bit mmio, input bit part, input string nm,
                             input logic [19:0] got);
        logic [19:0] exp;
        exp = model(mmio, part, addr, io_m, rd_n, wr_n);
        cmp_field("R1 R2 R3 R4", {nm, " strobes"}, 16'(got[19:16]), 16'(exp[19:16]));
        cmp_field(part ? "R6 R9 R4" : "R5 R4", {nm, " chip selects"}, 16'(got[15:8]), 16'(exp[15:8]));
        cmp_field(mmio ? "R9 R10" : "R8 R10", {nm, " port selects"}, 16'(got[7:0]), 16'(exp[7:0]));
        checks++;
        if ($countones(~got[15:0]) > 1) begin
            fails++;
            $display("FAIL R7 %s selects low=%0d expected<=1", nm, $countones(~got[15:0]));
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic m_io, input logic r_n, input logic w_n);
        @(posedge clk);
        addr = a; io_m = m_io; rd_n = r_n; wr_n = w_n;
        @(negedge clk);
        check_dut(1'b0, 1'b0, "iso_full", {a_mr, a_mw, a_ir, a_iw, a_cs, a_pi, a_po});
        check_dut(1'b1, 1'b1, "mm_part",  {b_mr, b_mw, b_ir, b_iw, b_cs, b_pi, b_po});
    endtask

    task automatic all_combos(input logic [15:0] a);
        for (int c = 0; c < 8; c++) apply(a, c[2], c[1], c[0]);
    endtask

    always @(posedge clk) begin
        if (!done) begin
            cycles++;
            if (cycles > WDOG) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: idle bus, every output inactive (R4)
        checks++;
        if ({a_mr, a_mw, a_ir, a_iw, a_cs, a_pi, a_po, b_cs, b_pi, b_po} !== '1) begin
            fails++;
            $display("FAIL R4 reset idle outputs actual=%h expected=all ones",
                     {a_mr, a_mw, a_ir, a_iw, a_cs, a_pi, a_po});
        end
        rst = 1'b0;

        // R5 R6: every chip boundary and its aliases
        for (int n = 0; n < 8; n++) begin
            all_combos(16'(n * 8192));
            all_combos(16'(n * 8192 + 8191));
        end
        // R8 R9: every port address and every ignore-mask alias
        for (int k = 0; k < NP; k++) begin
            for (int al = 0; al < 4; al++) begin
                all_combos({8'h00, P_BASE + 8'(k)} | 16'(al << 4));
                all_combos({8'hA5, P_BASE + 8'(k)} | 16'(al << 4));
                all_combos((M_BASE + 16'(k)) | 16'(al << 4));
                all_combos(((M_BASE + 16'(k)) | 16'(al << 4)) ^ 16'h0100);
            end
        end
        // R1..R10 broad sweep of the address space
        for (int a = 0; a < 65536; a += 5) all_combos(16'(a));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule